// File: doc/BRIEF.md
# Serial Receiver and Transmitter with Sticky Status Flags

This block turns an asynchronous serial line into bytes and back. Frames carry one start bit, a word of 5 to 8 data bits sent least significant bit first, an optional parity bit of selectable sense, and one stop bit. The receive side samples the line at sixteen times the bit rate, taking one sample for each pulse of an external baud tick. Each decoded word goes into a one-deep receive buffer. The transmit side has a one-deep holding register that feeds a shift register.

Eight sticky flags in a byte-wide status register record what happened on the line. The flags cover lost data, a bad stop bit, a bad parity bit, a received node address, a break, new receive data, a free transmit holding register, and an idle transmit shifter. The interrupt output is the OR of all eight flags. Software can only clear flags, so service code can acknowledge one cause without losing the others. An optional address mode filters incoming words against a node address, so the CPU is only disturbed when its own address arrives.

Register map on the 2-bit bus address: 0 reads the receive buffer and writes the transmit holding register, 1 is the status register, 2 is the line control register, 3 is the node address.

Top module: `sci_stat_top`

## Requirements
- R1: Control register bits [1:0] select the word length (5 plus the field value), bit 2 enables parity and bit 3 selects odd parity. Reset value is 0x03, which gives 8 data bits and no parity. A received word is loaded LSB first into the receive buffer, with unused high bits reading 0, and status bit 2 (data pending) is set.
- R2: A start bit is accepted only if the majority of the three samples around mid-bit is low. A shorter low glitch produces no flag and no load.
- R3: Status bit 5 is set when parity is enabled and the received parity bit disagrees with the selected sense. Even parity makes the total count of ones even. The word is still loaded.
- R4: Status bit 6 is set when the stop bit is sampled low, and the word is still loaded into the receive buffer.
- R5: Status bit 7 is set when a word is loaded while the previous one has not yet been read at address 0. The buffer then holds the newer word.
- R6: When the line is low from the start bit through the stop bit, only status bit 3 (break) is set. Nothing is loaded.
- R7: With control bit 4 set, a word not equal to the node address (address 3) is discarded with no flag. A matching word is loaded and sets bits 4 and 2. A matching word with a bad stop bit also sets bit 6 and is still loaded.
- R8: A write to the status register clears each bit written 0 and keeps each bit written 1. Software never sets a bit. A hardware set in the same cycle as a clear wins.
- R9: The interrupt output is high exactly when any status bit is set. After reset the status reads 0, the interrupt is low and the tx line is high.
- R10: A write to address 0 queues a byte for transmission, framed by the control register settings. Status bit 1 sets when the byte moves into the shift register. Status bit 0 sets when the shifter finishes its stop bit with nothing queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line, idles high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (marks receive buffer read) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | OR of all status flags |

## Verification
The bench sends a word again before reading the previous one. A design that kept the old byte, or that raised no overrun, fails there. A full-word low line must give a break alone; a receiver that also reports a framing error or loads a zero byte is flagged. A short low glitch checks start rejection, and a design that samples only the first edge would decode a phantom 0xFF. Address mode is driven with a foreign word, a matching word and a matching word with a bad stop bit, which catches filters that drop corrupted addresses. Selective status writes show whether a write of 1 wrongly sets or clears a bit.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int OVS = 16;
    localparam int DW  = 8;

    localparam int ST_OVR = 7;
    localparam int ST_FRM = 6;
    localparam int ST_PAR = 5;
    localparam int ST_ADR = 4;
    localparam int ST_BRK = 3;
    localparam int ST_RXD = 2;
    localparam int ST_TBE = 1;
    localparam int ST_TSE = 0;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_NODE = 2'd3;

    typedef struct packed {
        logic       par_odd;
        logic       par_en;
        logic [1:0] len_sel;
    } frame_fmt_t;

    typedef struct packed {
        logic       addr_mode;
        frame_fmt_t fmt;
    } line_cfg_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          par_bad;
        logic          stop_bad;
        logic          brk;
    } rx_word_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_st_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_st_e;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic [3:0] word_bits(input frame_fmt_t f);
        return 4'd5 + {2'b00, f.len_sel};
    endfunction

    // parity bit value that the line must carry for the selected sense
    function automatic logic par_calc(input logic [DW-1:0] d, input frame_fmt_t f);
        logic [DW-1:0] mask;
        mask = ~({DW{1'b1}} << word_bits(f));
        return f.par_odd ^ (^(d & mask));
    endfunction

endpackage

// File: rtl/sci_rx_core.sv
module sci_rx_core
    import sci_pkg::*;
#(
    parameter int OVS_N = OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  frame_fmt_t fmt,
    output logic       word_vld,
    output rx_word_t   word
);
    localparam int CW = $clog2(OVS_N);
    localparam logic [CW-1:0] S0  = CW'(OVS_N / 2 - 1);
    localparam logic [CW-1:0] S1  = CW'(OVS_N / 2);
    localparam logic [CW-1:0] S2  = CW'(OVS_N / 2 + 1);

    rx_st_e        st;
    logic [CW-1:0] cnt;
    logic [1:0]    smp;
    logic [2:0]    idx;
    logic [DW-1:0] shr;
    logic          zeros;
    logic          pbit;
    logic          bv;

    assign bv = vote3({smp, rxd});

    always_ff @(posedge clk) begin
        word_vld <= 1'b0;
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            smp   <= '0;
            idx   <= '0;
            shr   <= '0;
            zeros <= 1'b0;
            pbit  <= 1'b0;
            word  <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
            if (cnt == S0 || cnt == S1) smp <= {smp[0], rxd};
            case (st)
                RX_IDLE: if (!rxd) begin
                    st  <= RX_START;
                    cnt <= CW'(1);
                end
                RX_HOLD: if (rxd) st <= RX_IDLE;
                default: if (cnt == S2) begin
                    case (st)
                        RX_START: begin
                            if (bv) st <= RX_IDLE;
                            else begin
                                st    <= RX_DATA;
                                idx   <= '0;
                                shr   <= '0;
                                zeros <= 1'b1;
                            end
                        end
                        RX_DATA: begin
                            shr[idx] <= bv;
                            zeros    <= zeros & ~bv;
                            if ({1'b0, idx} == word_bits(fmt) - 4'd1)
                                st <= fmt.par_en ? RX_PAR : RX_STOP;
                            else
                                idx <= idx + 3'd1;
                        end
                        RX_PAR: begin
                            pbit  <= bv;
                            zeros <= zeros & ~bv;
                            st    <= RX_STOP;
                        end
                        RX_STOP: begin
                            word.data     <= shr;
                            word.stop_bad <= ~bv;
                            word.par_bad  <= fmt.par_en && (pbit != par_calc(shr, fmt));
                            word.brk      <= zeros & ~bv;
                            word_vld      <= 1'b1;
                            st            <= bv ? RX_IDLE : RX_HOLD;
                        end
                        default: st <= RX_IDLE;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/sci_tx_core.sv
module sci_tx_core
    import sci_pkg::*;
#(
    parameter int OVS_N = OVS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  frame_fmt_t    fmt,
    input  logic          load_we,
    input  logic [DW-1:0] load_data,
    output logic          txd,
    output logic          buf_took,
    output logic          shift_done
);
    localparam int CW = $clog2(OVS_N);
    localparam logic [CW-1:0] LAST = CW'(OVS_N - 1);

    tx_st_e        st;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [DW-1:0] sh;
    logic [DW-1:0] hold_q;
    logic          hold_full;
    logic          pbit;

    always_ff @(posedge clk) begin
        buf_took   <= 1'b0;
        shift_done <= 1'b0;
        if (rst) begin
            st        <= TX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            sh        <= '0;
            hold_q    <= '0;
            hold_full <= 1'b0;
            pbit      <= 1'b0;
        end else begin
            if (load_we) begin
                hold_q    <= load_data;
                hold_full <= 1'b1;
            end
            case (st)
                TX_IDLE: if (hold_full) begin
                    sh        <= hold_q;
                    pbit      <= par_calc(hold_q, fmt);
                    hold_full <= load_we;
                    buf_took  <= 1'b1;
                    st        <= TX_START;
                    cnt       <= '0;
                    idx       <= '0;
                end
                default: if (tick) begin
                    cnt <= cnt + CW'(1);
                    if (cnt == LAST) begin
                        case (st)
                            TX_START: st <= TX_DATA;
                            TX_DATA: begin
                                if ({1'b0, idx} == word_bits(fmt) - 4'd1)
                                    st <= fmt.par_en ? TX_PAR : TX_STOP;
                                else
                                    idx <= idx + 3'd1;
                            end
                            TX_PAR:  st <= TX_STOP;
                            default: begin
                                st         <= TX_IDLE;
                                shift_done <= ~(hold_full | load_we);
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[idx];
            TX_PAR:   txd = pbit;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sci_flag_reg.sv
module sci_flag_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_we,
    input  logic [W-1:0] keep_mask,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) flags[i] <= 1'b0;
            else     flags[i] <= (flags[i] & (~clr_we | keep_mask[i])) | hw_set[i];
        end
    end
endmodule

// File: rtl/sci_stat_top.sv
module sci_stat_top
    import sci_pkg::*;
#(
    parameter int OVS_N       = OVS,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rx_i,
    output logic       tx_o,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_o
);
    logic                   rxd_s;
    logic [SYNC_STAGES-1:0] sync_q;

    if (SYNC_STAGES == 1) begin : g_sync1
        always_ff @(posedge clk) sync_q <= rst ? 1'b1 : rx_i;
    end else begin : g_syncn
        always_ff @(posedge clk) begin
            if (rst) sync_q <= '1;
            else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
        end
    end
    assign rxd_s = sync_q[SYNC_STAGES-1];

    line_cfg_t     cfg_q;
    logic [DW-1:0] node_q;
    logic [DW-1:0] rbuf_q;
    logic          unread_q;
    logic [7:0]    flags_q;
    logic [7:0]    hw_set;
    logic          load;
    logic          rw_vld;
    rx_word_t      rw;
    logic          tx_took;
    logic          tx_done;

    sci_rx_core #(.OVS_N(OVS_N)) rx_i0 (
        .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rxd_s), .fmt(cfg_q.fmt),
        .word_vld(rw_vld), .word(rw)
    );

    sci_tx_core #(.OVS_N(OVS_N)) tx_i0 (
        .clk(clk), .rst(rst), .tick(baud_tick), .fmt(cfg_q.fmt),
        .load_we(bus_wr && bus_addr == A_DATA), .load_data(bus_wdata),
        .txd(tx_o), .buf_took(tx_took), .shift_done(tx_done)
    );

    always_comb begin
        hw_set = '0;
        load   = 1'b0;
        if (rw_vld) begin
            if (rw.brk) begin
                hw_set[ST_BRK] = 1'b1;
            end else if (!cfg_q.addr_mode || rw.data == node_q) begin
                load           = 1'b1;
                hw_set[ST_RXD] = 1'b1;
                hw_set[ST_FRM] = rw.stop_bad;
                hw_set[ST_PAR] = rw.par_bad;
                hw_set[ST_OVR] = unread_q;
                hw_set[ST_ADR] = cfg_q.addr_mode;
            end
        end
        hw_set[ST_TBE] = tx_took;
        hw_set[ST_TSE] = tx_done;
    end

    sci_flag_reg #(.W(8)) flag_i0 (
        .clk(clk), .rst(rst), .clr_we(bus_wr && bus_addr == A_STAT),
        .keep_mask(bus_wdata), .hw_set(hw_set), .flags(flags_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= line_cfg_t'(5'b00011);
            node_q   <= '0;
            rbuf_q   <= '0;
            unread_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) cfg_q  <= line_cfg_t'(bus_wdata[4:0]);
            if (bus_wr && bus_addr == A_NODE) node_q <= bus_wdata;
            if (load) begin
                rbuf_q   <= rw.data;
                unread_q <= 1'b1;
            end else if (bus_rd && bus_addr == A_DATA) begin
                unread_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = rbuf_q;
            A_STAT:  bus_rdata = flags_q;
            A_CTRL:  bus_rdata = {3'b000, cfg_q};
            default: bus_rdata = node_q;
        endcase
    end

    assign irq_o = |flags_q;
endmodule

// File: rtl/sci_stat_chk.sv
module sci_stat_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] flags,
    input logic [7:0] hw_set,
    input logic       irq,
    input logic       rw_vld,
    input logic       rw_brk,
    input logic       load,
    input logic       unread
);
    // R8: no flag appears without a hardware set in the cycle before
    a_r8_sw_never_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & ~($past(flags) | $past(hw_set))) == 8'h00));

    // R8: a hardware set always lands, whatever software writes
    a_r8_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
        (hw_set != 8'h00) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    // R9: interrupt only rises after a hardware event
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(hw_set) != 8'h00));

    // R6: a break word is never loaded
    a_r6_break_no_load: assert property (@(posedge clk) disable iff (rst)
        (rw_vld && rw_brk) |-> !load);

    // R6: a break word raises the break flag
    a_r6_break_flag: assert property (@(posedge clk) disable iff (rst)
        (rw_vld && rw_brk) |=> flags[3]);

    // R5: loading over unread data raises overrun
    a_r5_overrun: assert property (@(posedge clk) disable iff (rst)
        (load && unread) |=> flags[7]);
endmodule

bind sci_stat_top sci_stat_chk chk_i (
    .clk(clk), .rst(rst), .flags(flags_q), .hw_set(hw_set), .irq(irq_o),
    .rw_vld(rw_vld), .rw_brk(rw.brk), .load(load), .unread(unread_q)
);

// File: tb/sci_stat_top_tb_top.sv
module sci_stat_top_tb_top;
    import sci_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = OVS * 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_i = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tx_o;
    logic       irq_o;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        string      req;
        logic [7:0] stat;
        logic [7:0] data;
        bit         has_data;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) baud_tick <= rst ? 1'b0 : ~baud_tick;

    sci_stat_top dut_i (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_i(rx_i), .tx_o(tx_o),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                              input bit podd, input bit pflip, input bit stopv);
        logic p;
        @(negedge clk);
        rx_i = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        p = podd;
        for (int i = 0; i < nb; i++) begin
            rx_i = d[i];
            p ^= d[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        if (pen) begin
            rx_i = p ^ pflip;
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx_i = stopv;
        repeat (BIT_CLKS) @(negedge clk);
        rx_i = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic expect_item(input string req, input logic [7:0] st,
                               input logic [7:0] d, input bit hd);
        exp_t e;
        e.req = req; e.stat = st; e.data = d; e.has_data = hd;
        sb_q.push_back(e);
    endtask

    // monitor side of the scoreboard: pops one expected item and compares
    task automatic check_sb();
        exp_t e;
        logic [7:0] v;
        if (sb_q.size() == 0) begin
            check("scoreboard empty", 8'h00, 8'h01);
            return;
        end
        e = sb_q.pop_front();
        bus_read(A_STAT, v);
        check(e.req, v, e.stat);
        check({"R9 irq ", e.req}, {7'b0, irq_o}, {7'b0, e.stat != 8'h00});
        if (e.has_data) begin
            bus_read(A_DATA, v);
            check({e.req, " data"}, v, e.data);
        end
        bus_write(A_STAT, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] cap;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R9 reset state
        bus_read(A_STAT, v);
        check("R9 reset status", v, 8'h00);
        check("R9 reset irq", {7'b0, irq_o}, 8'h00);
        check("R9 reset tx idle", {7'b0, tx_o}, 8'h01);
        bus_read(A_CTRL, v);
        check("R1 reset control", v, 8'h03);

        // R1 8N1 word
        expect_item("R1 8N1", 8'h04, 8'hA5, 1'b1);
        send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        check_sb();

        // R1 5-bit word
        bus_write(A_CTRL, 8'h00);
        expect_item("R1 5-bit", 8'h04, 8'h16, 1'b1);
        send_frame(8'h16, 5, 1'b0, 1'b0, 1'b0, 1'b1);
        check_sb();

        // R3 7-bit even parity, correct
        bus_write(A_CTRL, 8'h06);
        expect_item("R3 even ok", 8'h04, 8'h35, 1'b1);
        send_frame(8'h35, 7, 1'b1, 1'b0, 1'b0, 1'b1);
        check_sb();

        // R3 odd parity, wrong parity bit; R8 selective clearing
        bus_write(A_CTRL, 8'h0E);
        send_frame(8'h35, 7, 1'b1, 1'b1, 1'b1, 1'b1);
        bus_read(A_STAT, v);
        check("R3 parity error", v, 8'h24);
        bus_read(A_DATA, v);
        check("R3 data kept", v, 8'h35);
        bus_write(A_STAT, 8'hFF);
        bus_read(A_STAT, v);
        check("R8 write ones keeps", v, 8'h24);
        bus_write(A_STAT, 8'hFB);
        bus_read(A_STAT, v);
        check("R8 clear one bit", v, 8'h20);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, v);
        check("R8 clear all", v, 8'h00);

        // R4 framing error
        bus_write(A_CTRL, 8'h03);
        expect_item("R4 framing", 8'h44, 8'hC3, 1'b1);
        send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        check_sb();

        // R5 overrun: two words, no read in between
        expect_item("R5 overrun", 8'h84, 8'h3C, 1'b1);
        send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        check_sb();

        // R6 break: low for start, 8 data, stop
        @(negedge clk);
        rx_i = 1'b0;
        repeat (10 * BIT_CLKS) @(negedge clk);
        rx_i = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        expect_item("R6 break", 8'h08, 8'h00, 1'b0);
        check_sb();
        bus_read(A_DATA, v);
        check("R6 buffer untouched", v, 8'h3C);

        // R2 short glitch rejected
        @(negedge clk);
        rx_i = 1'b0;
        repeat (6) @(negedge clk);
        rx_i = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        expect_item("R2 glitch", 8'h00, 8'h00, 1'b0);
        check_sb();

        // R7 address mode
        bus_write(A_NODE, 8'h42);
        bus_write(A_CTRL, 8'h13);
        expect_item("R7 foreign word", 8'h00, 8'h00, 1'b0);
        send_frame(8'h10, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        check_sb();
        expect_item("R7 match", 8'h14, 8'h42, 1'b1);
        send_frame(8'h42, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        check_sb();
        expect_item("R7 match framing", 8'h54, 8'h42, 1'b1);
        send_frame(8'h42, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        check_sb();
        bus_write(A_CTRL, 8'h03);

        // R10 transmit 0x5A in 8N1
        bus_write(A_DATA, 8'h5A);
        for (int k = 0; k < 4 * BIT_CLKS; k++) begin
            if (tx_o == 1'b0) break;
            @(negedge clk);
        end
        check("R10 start bit", {7'b0, tx_o}, 8'h00);
        bus_read(A_STAT, v);
        check("R10 buffer empty only", v, 8'h02);
        repeat (BIT_CLKS / 2 - 2) @(negedge clk);
        cap = 8'h00;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_CLKS) @(negedge clk);
            cap[i] = tx_o;
        end
        check("R10 tx data", cap, 8'h5A);
        repeat (BIT_CLKS) @(negedge clk);
        check("R10 stop bit", {7'b0, tx_o}, 8'h01);
        repeat (BIT_CLKS) @(negedge clk);
        expect_item("R10 both empty", 8'h03, 8'h00, 1'b0);
        check_sb();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule